// File: doc/BRIEF.md
# Multi-Channel Counter Interrupt Aggregator

This block merges the event outputs of a bank of counter channels into a single interrupt request line. Every channel offers four event strobes: carry, compare, borrow and index. A 2-bit trigger code for each channel picks which of these strobes can raise a request for that channel. Strobes that pass a per-channel mask set sticky pending bits. The pending bits can be read over a small byte-wide register bus. While the interrupt function is switched on, the interrupt line is high whenever any pending bit is set.

Software handles an interrupt in three steps. It reads the pending vector, services the channels whose bits are set, and then writes the enable command to the channel operation register. That one write clears every pending bit at once; there is no per-bit clear. The same register also accepts a command that switches the interrupt function off. The block also has a cable-status register for differential encoder inputs. Each channel's cable check is enabled by writing a 0 to that channel's bit. When read, a bit is 0 only for an enabled channel whose cable input reports a fault.

The counters that produce the event strobes are outside this block.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pending vector is all zero, the interrupt output is low, the interrupt function is off, the mask is all zero, and the cable register reads 0xFF because every check is disabled.
- R2: Channel i takes its trigger code from trig_sel[2i+1:2i]. Code 0 accepts carry, code 1 accepts compare, code 2 accepts carry or borrow, and code 3 accepts index. Strobes that the code does not select are ignored.
- R3: The mask is written at offset 0x12, with bit i for channel i. A selected strobe sets pending bit i at the next clock edge only while mask bit i is 1. Writing 0x00 blocks every channel.
- R4: Once set, a pending bit stays set until a clear command arrives. Later mask writes and trigger-code changes do not clear it.
- R5: A read at offset 0x10 returns the pending vector, with bit i for channel i. Reads of unmapped offsets return 0.
- R6: Writing 0x04 at offset 0x11 turns the interrupt function on and clears all pending bits at that clock edge. Values other than 0x04 and 0x01 written there have no effect.
- R7: Writing 0x01 at offset 0x11 turns the interrupt function off and forces the interrupt output low. The pending bits are kept.
- R8: The interrupt output equals the OR of all pending bits while the interrupt function is on. It changes in the same cycle as the pending vector.
- R9: If a selected, unmasked strobe and a clear command arrive in the same cycle, the strobe wins and its pending bit is set after that edge.
- R10: The cable register at offset 0x17 holds active-low per-channel enables and is written as a byte. Read bit i is 0 only when enable bit i is 0 and cable_good[i] is 0; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_addr | input | 5 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| evt_carry | input | 8 | Per-channel carry strobes |
| evt_compare | input | 8 | Per-channel compare strobes |
| evt_borrow | input | 8 | Per-channel borrow strobes |
| evt_index | input | 8 | Per-channel index strobes |
| trig_sel | input | 16 | Per-channel 2-bit trigger codes |
| cable_good | input | 8 | Per-channel cable state, 0 means fault |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
The assertions assume the following about the inputs:
- Event strobes, trigger codes and bus signals are known, clocked levels.
- A write is a single-cycle strobe whose offset and data are valid during that cycle.

The stimulus respects this by changing every input only on the falling clock edge and by keeping the write strobe to one cycle per register access. The sweep covers every channel, every trigger code and every strobe type. It also drives a clear command together with a strobe, so that the property that the strobe wins is exercised on a real collision.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  typedef enum logic [1:0] {
    TRIG_CARRY        = 2'd0,
    TRIG_COMPARE      = 2'd1,
    TRIG_CARRY_BORROW = 2'd2,
    TRIG_INDEX        = 2'd3
  } trig_e;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_PENDING = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CHAN_OP = 5'h11;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 5'h12;
  localparam logic [ADDR_W-1:0] OFS_CABLE   = 5'h17;

  localparam logic [DATA_W-1:0] OP_IRQ_ON  = 8'h04;
  localparam logic [DATA_W-1:0] OP_IRQ_OFF = 8'h01;
endpackage

// File: rtl/irq_event_select.sv
module irq_event_select
  import irqagg_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0]   carry,
  input  logic [N_CH-1:0]   compare,
  input  logic [N_CH-1:0]   borrow,
  input  logic [N_CH-1:0]   index,
  input  logic [2*N_CH-1:0] trig_sel,
  output logic [N_CH-1:0]   hit
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    trig_e code;
    assign code = trig_e'(trig_sel[2*i +: 2]);
    always_comb begin
      unique case (code)
        TRIG_CARRY:        hit[i] = carry[i];
        TRIG_COMPARE:      hit[i] = compare[i];
        TRIG_CARRY_BORROW: hit[i] = carry[i] | borrow[i];
        TRIG_INDEX:        hit[i] = index[i];
        default:           hit[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] hit,
  input  logic [N_CH-1:0] mask,
  input  logic            clear,
  output logic [N_CH-1:0] pend
);
  logic [N_CH-1:0] pend_nxt;
  logic [N_CH-1:0] armed;

  assign armed = hit & mask;

  always_comb begin
    pend_nxt = pend;
    if (clear) pend_nxt = '0;
    pend_nxt = pend_nxt | armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end

  // R3
  no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(hit & mask)) == '0));

  // R9
  event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & mask) != '0) |=> ((pend & $past(hit & mask)) == $past(hit & mask)));

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: rtl/cable_status_reg.sv
module cable_status_reg #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [N_CH-1:0] wdata,
  input  logic [N_CH-1:0] cable_good,
  output logic [N_CH-1:0] status
);
  logic [N_CH-1:0] en_n, en_n_nxt;

  always_comb begin
    en_n_nxt = en_n;
    if (wr_en) en_n_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_n <= '1;
    else        en_n <= en_n_nxt;
  end

  assign status = en_n | cable_good;

  // R10
  cable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((status | cable_good) == ($past(wdata) | cable_good)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [N_CH-1:0]     evt_carry,
  input  logic [N_CH-1:0]     evt_compare,
  input  logic [N_CH-1:0]     evt_borrow,
  input  logic [N_CH-1:0]     evt_index,
  input  logic [2*N_CH-1:0]   trig_sel,
  input  logic [N_CH-1:0]     cable_good,
  output logic                irq_o
);
  localparam int PAD_W = DATA_W - N_CH;

  logic            wr_op, wr_mask, wr_cable;
  logic            op_on, op_off;
  logic [N_CH-1:0] mask, mask_nxt;
  logic            func_en, func_en_nxt;
  logic [N_CH-1:0] hit, pend, cable_stat;

  assign wr_op    = bus_wr && (bus_addr == OFS_CHAN_OP);
  assign wr_mask  = bus_wr && (bus_addr == OFS_MASK);
  assign wr_cable = bus_wr && (bus_addr == OFS_CABLE);
  assign op_on    = wr_op && (bus_wdata == OP_IRQ_ON);
  assign op_off   = wr_op && (bus_wdata == OP_IRQ_OFF);

  irq_event_select #(.N_CH(N_CH)) u_sel (
    .carry    (evt_carry),
    .compare  (evt_compare),
    .borrow   (evt_borrow),
    .index    (evt_index),
    .trig_sel (trig_sel),
    .hit      (hit)
  );

  irq_pending_bank #(.N_CH(N_CH)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .mask  (mask),
    .clear (op_on),
    .pend  (pend)
  );

  cable_status_reg #(.N_CH(N_CH)) u_cable (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_cable),
    .wdata      (bus_wdata[N_CH-1:0]),
    .cable_good (cable_good),
    .status     (cable_stat)
  );

  always_comb begin
    mask_nxt    = mask;
    func_en_nxt = func_en;
    if (wr_mask) mask_nxt = bus_wdata[N_CH-1:0];
    if (op_on)       func_en_nxt = 1'b1;
    else if (op_off) func_en_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '0;
      func_en <= 1'b0;
    end else begin
      mask    <= mask_nxt;
      func_en <= func_en_nxt;
    end
  end

  assign irq_o = func_en & (|pend);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_PENDING: bus_rdata = {{PAD_W{1'b0}}, pend};
      OFS_CABLE:   bus_rdata = {{PAD_W{1'b1}}, cable_stat};
      default:     bus_rdata = '0;
    endcase
  end

  // R7
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_off |=> !irq_o);

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_on && ((hit & mask) == '0)) |=> !irq_o);

  // R8
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend != '0));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  evt_carry = '0, evt_compare = '0, evt_borrow = '0, evt_index = '0;
  logic [15:0] trig_sel = '0;
  logic [7:0]  cable_good = '1;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_carry(evt_carry),
    .evt_compare(evt_compare), .evt_borrow(evt_borrow), .evt_index(evt_index),
    .trig_sel(trig_sel), .cable_good(cable_good), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // one-cycle strobe: ev 0 carry, 1 compare, 2 borrow, 3 index
  task automatic pulse(input int ev, input logic [7:0] chans);
    @(negedge clk);
    case (ev)
      0: evt_carry = chans;
      1: evt_compare = chans;
      2: evt_borrow = chans;
      default: evt_index = chans;
    endcase
    @(negedge clk);
    evt_carry = '0; evt_compare = '0; evt_borrow = '0; evt_index = '0;
  endtask

  function automatic logic selects(input int code, input int ev);
    case (code)
      0: return ev == 0;
      1: return ev == 1;
      2: return (ev == 0) || (ev == 2);
      default: return ev == 3;
    endcase
  endfunction

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h10, d); check("R1 pending", d, 8'h00);
    check("R1 irq", irq_o, 1'b0);
    rd(5'h17, d); check("R1 cable", d, 8'hFF);
    pulse(0, 8'hFF); // mask zero after reset
    rd(5'h10, d); check("R1 mask zero", d, 8'h00);
    rd(5'h05, d); check("R5 unmapped", d, 8'h00);

    // R2 R5 R8 sweep
    wr(5'h12, 8'hFF);
    wr(5'h11, 8'h04);
    for (int code = 0; code < 4; code++) begin
      trig_sel = {8{2'(code)}};
      for (int ch = 0; ch < 8; ch++) begin
        for (int ev = 0; ev < 4; ev++) begin
          logic [7:0] exp;
          exp = selects(code, ev) ? 8'(1 << ch) : 8'h00;
          pulse(ev, 8'(1 << ch));
          rd(5'h10, d); check("R2 R5 pending", d, exp);
          check("R8 irq", irq_o, exp != 0);
          wr(5'h11, 8'h04);
          rd(5'h10, d); check("R6 cleared", d, 8'h00);
        end
      end
    end

    // R3 partial mask and zero mask
    trig_sel = '0;
    wr(5'h12, 8'hFB);
    pulse(0, 8'hFF);
    rd(5'h10, d); check("R3 partial mask", d, 8'hFB);
    wr(5'h11, 8'h04);
    wr(5'h12, 8'h00);
    pulse(0, 8'hFF);
    rd(5'h10, d); check("R3 zero mask", d, 8'h00);
    check("R3 irq", irq_o, 1'b0);

    // R4 hold across mask and code change
    wr(5'h12, 8'h81);
    pulse(0, 8'h81);
    wr(5'h12, 8'h00);
    trig_sel = 16'hFFFF;
    repeat (5) @(negedge clk);
    rd(5'h10, d); check("R4 hold", d, 8'h81);

    // R6 other op value ignored
    wr(5'h11, 8'h02);
    rd(5'h10, d); check("R6 other op", d, 8'h81);
    check("R6 other op irq", irq_o, 1'b1);

    // R7 off keeps pending
    wr(5'h11, 8'h01);
    check("R7 irq off", irq_o, 1'b0);
    rd(5'h10, d); check("R7 pending kept", d, 8'h81);
    wr(5'h11, 8'h04);
    rd(5'h10, d); check("R6 clear", d, 8'h00);

    // R9 event and clear together
    wr(5'h12, 8'hFF);
    trig_sel = '0;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h11; bus_wdata = 8'h04; evt_carry = 8'h20;
    @(negedge clk);
    bus_wr = 1'b0; evt_carry = '0;
    rd(5'h10, d); check("R9 event wins", d, 8'h20);
    check("R9 irq", irq_o, 1'b1);

    // R10 cable
    for (int p = 0; p < 4; p++) begin
      logic [7:0] en_n, good;
      en_n = (p == 0) ? 8'h00 : (p == 1) ? 8'hF0 : (p == 2) ? 8'h5A : 8'hFF;
      good = 8'h33 ^ 8'(p * 17);
      cable_good = good;
      wr(5'h17, en_n);
      rd(5'h17, d); check("R10 cable", d, en_n | good);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule